// File: doc/BRIEF.md
# Multi-Channel Management Serial Slave

This block is the management-interface slave of a transceiver that has several channels. The station master drives a management clock of about 2.5 MHz into the block. The block uses that clock as an input only. All traffic, in both directions, travels on one bidirectional serial data line. That line is presented here as a separate input, output and output-enable, and the pad logic merges them.

Each frame is checked against a PHY address. The upper address bits must equal a strap input. The low bits choose one of the per-channel register sets. Within a set, only addresses 0–6 and 15–17 exist. Address 17 is a read-only window onto that channel's bit-error-test mismatch count. Every other address reads as zero and ignores writes.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is asserted and after it is released, `mdio_oe` is low, and every stored register reads back 0x0000.
- R2: A frame is accepted only after at least 32 consecutive ones on `mdio_i`, followed by the start bits 0 then 1. A frame preceded by fewer than 32 ones neither drives the line nor changes any register.
- R3: After the start bits come a 2-bit opcode, a 5-bit PHY address, a 5-bit register address and a 2-bit turnaround, followed by 16 data bits. Every field is sent MSB first. With opcode 01 (write) to an implemented, writable address, the register is updated, and a later read with opcode 10 returns the written value.
- R4: A read frame works as follows. In the cycle after the last register-address bit, `mdio_oe` stays low. In the next cycle, `mdio_oe` is high and `mdio_o` is 0. Data bits 15 down to 0 then follow, one per cycle. `mdio_oe` falls after exactly 17 high cycles. Outputs change only after a rising edge of `mdc`.
- R5: PHY address bits [1:0] select the channel (00, 01, 10, 11 for the first to fourth channels). The channels keep independent contents at the same register address.
- R6: If PHY address bits [4:2] differ from `phy_strap`, the frame is ignored. The line is not driven, and no register changes.
- R7: Register addresses 7–14 and 18–31 read as 0x0000, and writes to them change nothing. Addresses 0–6, 15 and 16 are stored read/write registers.
- R8: Address 17 reads the selected channel's `bert_err_cnt` byte, zero-extended to 16 bits. That byte is bits [8c+7:8c] for channel c. Writes to address 17 have no effect.
- R9: Frames with opcode 00 or 11 never drive the line and never change a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the station master |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| phy_strap | input | 3 | Required value of PHY address bits [4:2] |
| bert_err_cnt | input | 32 | Per-channel 8-bit mismatch counts, channel c in bits [8c+7:8c] |

## Verification
The assertions assume that the master sends complete frames. They also assume that the master never starts a new preamble while a read turnaround or read data phase is still running. If that assumption failed, the drive window could be cut short by reset only. They also assume that `bert_err_cnt` is stable for the cycle in which a read frame's address is decoded. The stimulus begins every frame with two zero bits, which clears any leftover count of ones. It drives whole frames only. It changes the error counts only between frames, so every frame stays within these assumptions.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int OP_W      = 2;
    localparam int HDR_BITS  = OP_W + 2 * ADDR_W;
    localparam int TA_BITS   = 2;
    localparam int PRE_MIN   = 32;
    localparam int WR_BITS   = TA_BITS + DATA_W;

    // implemented address map: a low window, a high window, error count at top
    localparam logic [ADDR_W-1:0] LOW_TOP   = 5'd6;
    localparam logic [ADDR_W-1:0] HIGH_BASE = 5'd15;
    localparam logic [ADDR_W-1:0] ERR_REG   = 5'd17;
    localparam int NSTORE = int'(LOW_TOP) + 1 + int'(ERR_REG) - int'(HIGH_BASE);
    localparam int IDX_W  = $clog2(NSTORE + 1);

    localparam logic [OP_W-1:0] OP_RD = 2'b10;
    localparam logic [OP_W-1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_PRE     = 3'd0,
        ST_START   = 3'd1,
        ST_HDR     = 3'd2,
        ST_RD_TA   = 3'd3,
        ST_RD_DATA = 3'd4,
        ST_WR      = 3'd5
    } frame_st_e;

    function automatic logic reg_present(input logic [ADDR_W-1:0] a);
        return (a <= LOW_TOP) || ((a >= HIGH_BASE) && (a <= ERR_REG));
    endfunction

    function automatic logic reg_stored(input logic [ADDR_W-1:0] a);
        return reg_present(a) && (a != ERR_REG);
    endfunction

    function automatic logic [IDX_W-1:0] store_idx(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] t;
        t = (a <= LOW_TOP) ? a : (a - (HIGH_BASE - LOW_TOP - 5'd1));
        return t[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/mdio_frame_ctl.sv
`timescale 1ns/1ps
module mdio_frame_ctl
    import mdio_mgmt_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [4-CH_W:0]   strap,
    input  logic [DATA_W-1:0] rd_data,
    output logic [CH_W-1:0]   rd_ch,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_ch,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int ONES_W = $clog2(PRE_MIN) + 1;
    localparam int CNT_W  = $clog2(WR_BITS + 1);
    localparam logic [ONES_W-1:0] ONES_MIN = ONES_W'(PRE_MIN);
    localparam logic [CNT_W-1:0]  HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0]  RD_END   = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  WR_LAST  = CNT_W'(WR_BITS - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [ONES_W-1:0] ones;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [CH_W-1:0]   ch;
        logic [ADDR_W-1:0] ra;
        logic              oe;
        logic              dout;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [HDR_BITS-1:0] hdr;
    logic [OP_W-1:0]     op;
    logic                phy_hit;

    // header as it stands once the current bit is shifted in
    assign hdr     = {ctl_q.sh[HDR_BITS-2:0], mdio_i};
    assign op      = hdr[HDR_BITS-1 -: OP_W];
    assign rd_addr = hdr[ADDR_W-1:0];
    assign rd_ch   = hdr[ADDR_W +: CH_W];
    assign phy_hit = (hdr[2*ADDR_W-1:ADDR_W+CH_W] == strap);

    assign wr_en   = (ctl_q.st == ST_WR) && (ctl_q.cnt == WR_LAST) && reg_stored(ctl_q.ra);
    assign wr_ch   = ctl_q.ch;
    assign wr_addr = ctl_q.ra;
    assign wr_data = {ctl_q.sh[DATA_W-2:0], mdio_i};

    assign mdio_o  = ctl_q.dout;
    assign mdio_oe = ctl_q.oe;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_PRE: begin
                if (mdio_i) begin
                    if (ctl_q.ones < ONES_MIN) begin
                        ctl_d.ones = ctl_q.ones + 1'b1;
                    end
                end else if (ctl_q.ones >= ONES_MIN) begin
                    ctl_d.st = ST_START;
                end else begin
                    ctl_d.ones = '0;
                end
            end
            ST_START: begin
                ctl_d.ones = '0;
                ctl_d.cnt  = '0;
                ctl_d.st   = mdio_i ? ST_HDR : ST_PRE;
            end
            ST_HDR: begin
                ctl_d.sh  = {ctl_q.sh[DATA_W-2:0], mdio_i};
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == HDR_LAST) begin
                    ctl_d.cnt = '0;
                    ctl_d.ch  = rd_ch;
                    ctl_d.ra  = rd_addr;
                    if (phy_hit && (op == OP_RD)) begin
                        ctl_d.st = ST_RD_TA;
                        ctl_d.sh = rd_data;
                    end else if (phy_hit && (op == OP_WR)) begin
                        ctl_d.st = ST_WR;
                    end else begin
                        ctl_d.st = ST_PRE;
                    end
                end
            end
            ST_RD_TA: begin
                // first turnaround bit left floating, second one driven low
                ctl_d.oe   = 1'b1;
                ctl_d.dout = 1'b0;
                ctl_d.cnt  = '0;
                ctl_d.st   = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (ctl_q.cnt == RD_END) begin
                    ctl_d.oe   = 1'b0;
                    ctl_d.dout = 1'b0;
                    ctl_d.cnt  = '0;
                    ctl_d.st   = ST_PRE;
                end else begin
                    ctl_d.dout = ctl_q.sh[DATA_W-1];
                    ctl_d.sh   = {ctl_q.sh[DATA_W-2:0], 1'b0};
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                end
            end
            ST_WR: begin
                ctl_d.sh  = {ctl_q.sh[DATA_W-2:0], mdio_i};
                ctl_d.cnt = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == WR_LAST) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = ST_PRE;
                end
            end
            default: begin
                ctl_d.st   = ST_PRE;
                ctl_d.ones = '0;
                ctl_d.oe   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_PRE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/mdio_reg_bank.sv
`timescale 1ns/1ps
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CH_W  = 2,
    parameter int ERR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [CH_W-1:0]    rd_ch,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NCH*ERR_W-1:0] err_cnt,
    output logic [DATA_W-1:0]  rd_data
);

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_is_err;
    logic             rd_is_store;
    logic [NCH-1:0][DATA_W-1:0] ch_rd;

    assign wr_idx      = store_idx(wr_addr);
    assign rd_idx      = store_idx(rd_addr);
    assign rd_is_err   = (rd_addr == ERR_REG);
    assign rd_is_store = reg_stored(rd_addr);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DATA_W-1:0] word_q [NSTORE];
        logic [DATA_W-1:0] word_d [NSTORE];
        logic              sel;
        logic [DATA_W-1:0] rd_w;

        assign sel = wr_en && (wr_ch == CH_W'(g)) && (int'(wr_idx) < NSTORE);

        always_comb begin
            word_d = word_q;
            if (sel) begin
                word_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '{default: '0};
            end else begin
                word_q <= word_d;
            end
        end

        always_comb begin
            rd_w = '0;
            if (rd_is_err) begin
                rd_w = DATA_W'(err_cnt[g*ERR_W +: ERR_W]);
            end else if (rd_is_store) begin
                rd_w = word_q[rd_idx];
            end
        end

        assign ch_rd[g] = rd_w;
    end

    assign rd_data = ch_rd[rd_ch];

endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
    import mdio_mgmt_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int ERR_W = 8
) (
    input  logic                   mdc,
    input  logic                   rst_n,
    input  logic                   mdio_i,
    output logic                   mdio_o,
    output logic                   mdio_oe,
    input  logic [4-$clog2(NCH):0] phy_strap,
    input  logic [NCH*ERR_W-1:0]   bert_err_cnt
);

    localparam int CH_W = $clog2(NCH);

    logic [DATA_W-1:0] rd_data;
    logic [CH_W-1:0]   rd_ch;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [CH_W-1:0]   wr_ch;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    mdio_frame_ctl #(
        .CH_W (CH_W)
    ) frame_i (
        .clk     (mdc),
        .rst_n   (rst_n),
        .mdio_i  (mdio_i),
        .strap   (phy_strap),
        .rd_data (rd_data),
        .rd_ch   (rd_ch),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mdio_reg_bank #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .ERR_W (ERR_W)
    ) bank_i (
        .clk     (mdc),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_ch   (rd_ch),
        .rd_addr (rd_addr),
        .err_cnt (bert_err_cnt),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_chk
    import mdio_mgmt_pkg::*;
(
    input logic              mdc,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);

    localparam logic [4:0] DRIVE_LEN = 5'd17;

    logic [4:0] run_q, run_d;

    always_comb begin
        if (!mdio_oe) begin
            run_d = '0;
        end else if (run_q == 5'd31) begin
            run_d = run_q;
        end else begin
            run_d = run_q + 5'd1;
        end
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R4
    ta_low_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R4
    drive_window_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (run_q < DRIVE_LEN));

    // R4
    release_len_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe) |-> (run_q == DRIVE_LEN));

    // R7
    wr_impl_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_en |-> ((wr_addr <= LOW_TOP) || (wr_addr == HIGH_BASE) || (wr_addr == HIGH_BASE + 5'd1)));

    // R8
    err_ro_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_en |-> (wr_addr != ERR_REG));

    // R4
    no_write_while_drive_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> !wr_en);

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk chk_i (.*);

// File: tb/mdio_mgmt_slave_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_tb_top;

    localparam int CLK_PERIOD = 400;
    localparam int MAX_CYCLES = 200000;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_i = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic [31:0] err_cnt = 32'h0;
    logic        mdio_o;
    logic        mdio_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model [4][32];

    always #(CLK_PERIOD / 2) mdc = ~mdc;

    mdio_mgmt_slave dut_i (
        .mdc          (mdc),
        .rst_n        (rst_n),
        .mdio_i       (mdio_i),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .phy_strap    (strap),
        .bert_err_cnt (err_cnt)
    );

    function automatic bit is_stored(input logic [4:0] ra);
        return (ra <= 5'd6) || (ra == 5'd15) || (ra == 5'd16);
    endfunction

    function automatic logic [15:0] exp_read(input int ch, input logic [4:0] ra);
        if (ra == 5'd17) return {8'h00, err_cnt[ch*8 +: 8]};
        if (is_stored(ra)) return model[ch][ra];
        return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge mdc);
        mdio_i = b;
    endtask

    task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] wd, input string req);
        bit          acc;
        bit          drove;
        bit          shape_ok;
        logic [11:0] hdr;
        logic [15:0] exp;
        logic [15:0] got;
        int          ch;
        acc = (pre >= 32) && (phy[4:2] == strap) && (op == 2'b10 || op == 2'b01);
        ch  = int'(phy[1:0]);
        hdr = {op, phy, ra};
        exp = exp_read(ch, ra);
        drive_bit(1'b0);
        drive_bit(1'b0);
        repeat (pre) drive_bit(1'b1);
        drive_bit(1'b0);
        drive_bit(1'b1);
        for (int i = 11; i >= 0; i--) drive_bit(hdr[i]);
        drove = 1'b0;
        shape_ok = 1'b1;
        got = '0;
        for (int k = 0; k < 19; k++) begin
            logic b;
            if (op == 2'b10 || k == 0 || k == 18) b = 1'b1;
            else if (k == 1) b = 1'b0;
            else b = wd[17-k];
            drive_bit(b);
            if (mdio_oe === 1'b1) drove = 1'b1;
            if (k >= 2 && k < 18) got = {got[14:0], mdio_o};
            if (k == 0 || k == 18) shape_ok = shape_ok && (mdio_oe === 1'b0);
            else shape_ok = shape_ok && (mdio_oe === 1'b1);
            if (k == 1) shape_ok = shape_ok && (mdio_o === 1'b0);
        end
        if (acc && op == 2'b10) begin
            check(shape_ok, "R4", "turnaround and release timing", {31'd0, shape_ok}, 32'd1);
            check(got === exp, req, $sformatf("read ch%0d reg%0d", ch, ra), {16'd0, got}, {16'd0, exp});
        end else begin
            check(!drove, req, $sformatf("line left released reg%0d", ra), {31'd0, drove}, 32'd0);
            if (acc && op == 2'b01 && is_stored(ra)) model[ch][ra] = wd;
        end
    endtask

    task automatic wr(input int ch, input logic [4:0] ra, input logic [15:0] wd, input string req);
        run_frame(32, 2'b01, {strap, 2'(ch)}, ra, wd, req);
    endtask

    task automatic rd(input int ch, input logic [4:0] ra, input string req);
        run_frame(32, 2'b10, {strap, 2'(ch)}, ra, 16'h0, req);
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge mdc);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", MAX_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1207));
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 32; a++) model[c][a] = 16'h0;

        repeat (3) @(negedge mdc);
        check(mdio_oe === 1'b0, "R1", "oe during reset", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge mdc);
        check(mdio_oe === 1'b0, "R1", "oe after reset", {31'd0, mdio_oe}, 32'd0);
        rd(0, 5'd0, "R1");
        rd(3, 5'd16, "R1");

        wr(0, 5'd4, 16'hA5C3, "R3");
        rd(0, 5'd4, "R3");
        wr(0, 5'd0, 16'hFFFF, "R3");
        rd(0, 5'd0, "R3");
        wr(2, 5'd16, 16'h8001, "R3");
        rd(2, 5'd16, "R3");

        for (int c = 0; c < 4; c++) wr(c, 5'd5, 16'h1000 + 16'(c * 16'h0111), "R5");
        for (int c = 0; c < 4; c++) rd(c, 5'd5, "R5");

        run_frame(31, 2'b01, {strap, 2'd0}, 5'd5, 16'h5555, "R2");
        run_frame(31, 2'b10, {strap, 2'd0}, 5'd5, 16'h0, "R2");
        run_frame(32, 2'b10, {strap, 2'd0}, 5'd5, 16'h0, "R2");

        run_frame(32, 2'b01, {3'b011, 2'd1}, 5'd5, 16'hDEAD, "R6");
        run_frame(32, 2'b10, {3'b011, 2'd1}, 5'd5, 16'h0, "R6");
        run_frame(32, 2'b10, {3'b100, 2'd1}, 5'd5, 16'h0, "R6");
        rd(1, 5'd5, "R6");

        wr(0, 5'd7, 16'h1234, "R7");
        wr(0, 5'd14, 16'h2345, "R7");
        wr(0, 5'd18, 16'h3456, "R7");
        wr(0, 5'd31, 16'h4567, "R7");
        rd(0, 5'd7, "R7");
        rd(0, 5'd14, "R7");
        rd(0, 5'd18, "R7");
        rd(0, 5'd31, "R7");
        wr(1, 5'd6, 16'h6666, "R7");
        wr(1, 5'd15, 16'h0F0F, "R7");
        rd(1, 5'd6, "R7");
        rd(1, 5'd15, "R7");

        err_cnt = 32'hFF_80_01_3C;
        for (int c = 0; c < 4; c++) rd(c, 5'd17, "R8");
        wr(2, 5'd17, 16'hBEEF, "R8");
        rd(2, 5'd17, "R8");

        run_frame(32, 2'b00, {strap, 2'd0}, 5'd4, 16'h7777, "R9");
        run_frame(32, 2'b11, {strap, 2'd0}, 5'd4, 16'h8888, "R9");
        rd(0, 5'd4, "R9");

        for (int n = 0; n < 160; n++) begin
            int          pre;
            logic [1:0]  op;
            logic [4:0]  phy;
            logic [4:0]  ra;
            logic [15:0] wd;
            int          sel;
            string       tag;
            if (($urandom % 12) == 0) err_cnt = $urandom;
            pre = (($urandom % 10) == 0) ? 24 + int'($urandom % 8) : 32 + int'($urandom % 8);
            sel = int'($urandom % 20);
            op  = (sel < 9) ? 2'b10 : (sel < 18) ? 2'b01 : ((sel == 18) ? 2'b00 : 2'b11);
            phy = (($urandom % 8) == 0) ? 5'($urandom) : {strap, 2'($urandom)};
            ra  = 5'($urandom);
            wd  = 16'($urandom);
            if (pre < 32) tag = "R2";
            else if (op == 2'b00 || op == 2'b11) tag = "R9";
            else if (phy[4:2] != strap) tag = "R6";
            else if (ra == 5'd17) tag = "R8";
            else if (!is_stored(ra)) tag = "R7";
            else tag = "R3";
            run_frame(pre, op, phy, ra, wd, tag);
        end

        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 18; a++) rd(c, 5'(a), "R5");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule